// File: doc/BRIEF.md
# Complementary PWM Output Conditioning Stage

This block sits between a compare unit and the output pins. It turns one raw PWM level into two complementary drive phases. Group A carries the true phase and group B the inverted phase. A programmable gap is placed after every input edge. During that gap both phases rest at their inactive level. Each group then gets its own polarity inversion and its own output enable.

A shutdown input overrides everything else. It asserts without waiting for a clock and places each group in its own configured safe state: tri-stated, driven inactive or driven active. When trigger gating is enabled, the enables stay low until a trigger has been seen. A 3-bit mode field selects the single defined mode. Every other mode value leaves both groups undriven.

Top module: `pwm_out_stage`

## Requirements
- R1: With `dt_i` = 0, `a_o` and `b_o` show the level of `pwm_i` and its complement one clock after `pwm_i` is sampled, with no gap.
- R2: With `dt_i` = N (1..63), a phase becomes active only once `pwm_i` has held its new level for N further clocks after the edge is sampled. A phase goes inactive on the first clock after the edge. The two phases are never active together.
- R3: A high or low pulse of `pwm_i` that lasts N clocks or fewer, with N = `dt_i`, never activates the phase it would drive. The count starts again at the next edge.
- R4: The active level of a group's pin follows its polarity bit: bit 0 means active high and bit 1 means active low. Shutdown levels and idle levels use the same convention.
- R5: While shutdown is in effect, the group's 2-bit safe-state field selects the result: 2'b11 drives the active level, 2'b10 drives the inactive level, and 2'b00 or 2'b01 clears that group's enable.
- R6: Shutdown takes effect combinationally when `shdn_i` rises, with no clock needed. It overrides dead time and trigger gating. Normal output returns at the first rising clock edge that samples `shdn_i` low.
- R7: When `oe_on_trig_i` and `trig_en_i` are both high, both enables stay low until a clock edge samples `trig_i` high. From the following cycle on, the enables are high.
- R8: The trigger latch clears on any clock edge that samples `trig_en_i` low, and on reset. With `oe_on_trig_i` low, the enables do not depend on the trigger.
- R9: Any `mode_i` value other than 3'b000 clears both enables, whatever the shutdown state.
- R10: A group whose enable is low presents its inactive level on its pin. After reset, the sampled level reads as low with a zero count, so with `dt_i` = 0 phase B is active and phase A is inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pwm_i | input | 1 | Raw PWM level from the compare unit |
| shdn_i | input | 1 | Shutdown request, active high |
| trig_i | input | 1 | Trigger event |
| trig_en_i | input | 1 | Triggered operation enabled |
| oe_on_trig_i | input | 1 | Hold enables low until triggered |
| dt_i | input | 6 | Dead time in clocks, 0 disables |
| pol_a_i | input | 1 | Group A polarity, 1 = active low |
| pol_b_i | input | 1 | Group B polarity, 1 = active low |
| sd_a_i | input | 2 | Group A safe state on shutdown |
| sd_b_i | input | 2 | Group B safe state on shutdown |
| mode_i | input | 3 | Output mode, only 3'b000 defined |
| a_o | output | 1 | Group A pin level |
| a_oe_o | output | 1 | Group A output enable |
| b_o | output | 1 | Group B pin level |
| b_oe_o | output | 1 | Group B output enable |

## Verification
Every combination of polarity bits is run against dead times of 0, 1, 2, 3, 7 and 63. Each run uses a pulse train whose widths fall below, equal and exceed the dead time. This separates an edge passed straight through from a delayed edge, and shows whether a pulse of exactly N clocks is swallowed. All 64 safe-state and polarity combinations are exercised with shutdown raised between clock edges, both with trigger gating active and without it. Those runs check the combinational assertion and the release one edge later. Trigger arming, its clearing by the trigger enable, and every reserved mode are each walked through in turn.

// File: rtl/pwm_out_pkg.sv
package pwm_out_pkg;
  localparam int DT_W   = 6;
  localparam int MODE_W = 3;
  localparam int N_GRP  = 2;

  localparam logic [MODE_W-1:0] MODE_SINGLE = '0;

  typedef enum logic [1:0] {
    SD_TRI_0    = 2'b00,
    SD_TRI_1    = 2'b01,
    SD_INACTIVE = 2'b10,
    SD_ACTIVE   = 2'b11
  } sd_state_e;
endpackage

// File: rtl/pwm_dead_time.sv
module pwm_dead_time #(
  parameter int DT_W = 6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            pwm_i,
  input  logic [DT_W-1:0] dt_i,
  output logic            act_a_o,
  output logic            act_b_o
);
  localparam logic [DT_W-1:0] RUN_MAX = '1;

  logic            lvl_q;
  logic [DT_W-1:0] run_q;
  logic            settled;

  // run_q counts clocks the sampled level has held, saturating
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= 1'b0;
      run_q <= '0;
    end else if (pwm_i != lvl_q) begin
      lvl_q <= pwm_i;
      run_q <= '0;
    end else if (run_q != RUN_MAX) begin
      run_q <= run_q + 1'b1;
    end
  end

  assign settled = (run_q >= dt_i);
  assign act_a_o = lvl_q & settled;
  assign act_b_o = ~lvl_q & settled;

  // R2
  dt_rise_a_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((dt_i != '0) && $rose(act_a_o)) |-> $past(lvl_q));
  // R2
  dt_rise_b_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((dt_i != '0) && $rose(act_b_o)) |-> !$past(lvl_q));
  // R2
  no_overlap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(act_a_o && act_b_o));
endmodule

// File: rtl/pwm_trig_gate.sv
module pwm_trig_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  input  logic trig_en_i,
  input  logic oe_on_trig_i,
  output logic hold_o
);
  logic armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         armed_q <= 1'b0;
    else if (!trig_en_i) armed_q <= 1'b0;
    else if (trig_i)     armed_q <= 1'b1;
  end

  assign hold_o = oe_on_trig_i & trig_en_i & ~armed_q;

  // R7
  arm_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(armed_q) |-> $past(trig_i));
  // R8
  arm_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trig_en_i |=> !armed_q);
endmodule

// File: rtl/pwm_grp_drive.sv
module pwm_grp_drive
  import pwm_out_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       act_i,
  input  logic       pol_i,
  input  logic [1:0] sd_i,
  input  logic       shdn_i,
  input  logic       hold_i,
  input  logic       mode_ok_i,
  output logic       pin_o,
  output logic       oe_o
);
  sd_state_e sd_st;
  assign sd_st = sd_state_e'(sd_i);

  // priority: mode, shutdown, trigger hold, normal
  always_comb begin
    pin_o = pol_i;
    oe_o  = 1'b0;
    if (!mode_ok_i) begin
      oe_o = 1'b0;
    end else if (shdn_i) begin
      unique case (sd_st)
        SD_ACTIVE:   begin pin_o = ~pol_i; oe_o = 1'b1; end
        SD_INACTIVE: begin pin_o = pol_i;  oe_o = 1'b1; end
        default:     begin pin_o = pol_i;  oe_o = 1'b0; end
      endcase
    end else if (hold_i) begin
      oe_o = 1'b0;
    end else begin
      pin_o = act_i ^ pol_i;
      oe_o  = 1'b1;
    end
  end

  // R5
  sd_tri_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_ok_i && shdn_i && !sd_i[1]) |-> !oe_o);
  // R10
  idle_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_o |-> (pin_o == pol_i));
endmodule

// File: rtl/pwm_out_stage.sv
module pwm_out_stage
  import pwm_out_pkg::*;
#(
  parameter int DT_WIDTH = DT_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                pwm_i,
  input  logic                shdn_i,
  input  logic                trig_i,
  input  logic                trig_en_i,
  input  logic                oe_on_trig_i,
  input  logic [DT_WIDTH-1:0] dt_i,
  input  logic                pol_a_i,
  input  logic                pol_b_i,
  input  logic [1:0]          sd_a_i,
  input  logic [1:0]          sd_b_i,
  input  logic [MODE_W-1:0]   mode_i,
  output logic                a_o,
  output logic                a_oe_o,
  output logic                b_o,
  output logic                b_oe_o
);
  logic             act_a, act_b, hold, shdn_q, shdn_eff, mode_ok;
  logic [N_GRP-1:0] act_v, pol_v, pin_v, oe_v;
  logic [1:0]       sd_v [N_GRP];

  // asserts at once, releases on the first edge that samples it low
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) shdn_q <= 1'b0;
    else         shdn_q <= shdn_i;
  end
  assign shdn_eff = shdn_i | shdn_q;
  assign mode_ok  = (mode_i == MODE_SINGLE);

  pwm_dead_time #(.DT_W(DT_WIDTH)) u_dt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pwm_i   (pwm_i),
    .dt_i    (dt_i),
    .act_a_o (act_a),
    .act_b_o (act_b)
  );

  pwm_trig_gate u_trig (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .trig_i       (trig_i),
    .trig_en_i    (trig_en_i),
    .oe_on_trig_i (oe_on_trig_i),
    .hold_o       (hold)
  );

  assign act_v = {act_b, act_a};
  assign pol_v = {pol_b_i, pol_a_i};
  assign sd_v[0] = sd_a_i;
  assign sd_v[1] = sd_b_i;

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    pwm_grp_drive u_drv (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .act_i     (act_v[g]),
      .pol_i     (pol_v[g]),
      .sd_i      (sd_v[g]),
      .shdn_i    (shdn_eff),
      .hold_i    (hold),
      .mode_ok_i (mode_ok),
      .pin_o     (pin_v[g]),
      .oe_o      (oe_v[g])
    );
  end

  assign a_o    = pin_v[0];
  assign a_oe_o = oe_v[0];
  assign b_o    = pin_v[1];
  assign b_oe_o = oe_v[1];

  // R9
  reserved_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != MODE_SINGLE) |-> (!a_oe_o && !b_oe_o));
  // R6
  shdn_async_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shdn_i && mode_ok && sd_a_i == 2'b11) |-> (a_oe_o && a_o == ~pol_a_i));
  // R6
  shdn_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(shdn_i) && mode_ok && sd_b_i == 2'b10) |-> (b_oe_o && b_o == pol_b_i));
  // R2
  pin_overlap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_oe_o && b_oe_o && !shdn_eff) |-> !((a_o ^ pol_a_i) && (b_o ^ pol_b_i)));
endmodule

// File: tb/pwm_out_stage_tb.sv
`timescale 1ns/1ps
module pwm_out_stage_tb;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       pwm = 0, shdn = 0, trig = 0, trig_en = 0, oet = 0;
  logic [5:0] dt = 0;
  logic       pol_a = 0, pol_b = 0;
  logic [1:0] sd_a = 0, sd_b = 0;
  logic [2:0] mode = 0;
  logic       a_o, a_oe, b_o, b_oe;

  int errors = 0, checks = 0;
  bit done = 0;

  // bench model state
  logic       m_lvl = 0, m_armed = 0, m_shdn = 0;
  int         m_run = 0;

  always #2 clk = ~clk;

  pwm_out_stage u_dut (
    .clk_i(clk), .rst_ni(rst_n), .pwm_i(pwm), .shdn_i(shdn), .trig_i(trig),
    .trig_en_i(trig_en), .oe_on_trig_i(oet), .dt_i(dt), .pol_a_i(pol_a),
    .pol_b_i(pol_b), .sd_a_i(sd_a), .sd_b_i(sd_b), .mode_i(mode),
    .a_o(a_o), .a_oe_o(a_oe), .b_o(b_o), .b_oe_o(b_oe)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_lvl = 0; m_run = 0; m_armed = 0; m_shdn = 0;
    end else begin
      if (pwm != m_lvl) begin m_lvl = pwm; m_run = 0; end
      else if (m_run < 63) m_run = m_run + 1;
      if (!trig_en) m_armed = 0;
      else if (trig) m_armed = 1;
      m_shdn = shdn;
    end
  end

  function automatic void expect_grp(input logic act, input logic pol,
                                     input logic [1:0] sd, input logic hold,
                                     input logic sh, output logic pin,
                                     output logic oe);
    pin = pol; oe = 0;
    if (mode != 0) oe = 0;
    else if (sh) begin
      if (sd == 2'b11) begin pin = ~pol; oe = 1; end
      else if (sd == 2'b10) oe = 1;
    end else if (!hold) begin pin = act ^ pol; oe = 1; end
  endfunction

  task automatic check(input string req);
    logic ok_run, ea, eb, eao, ebo, hold, sh;
    ok_run = (m_run >= int'(dt));
    hold = oet & trig_en & ~m_armed;
    sh = shdn | m_shdn;
    expect_grp(m_lvl & ok_run, pol_a, sd_a, hold, sh, ea, eao);
    expect_grp(~m_lvl & ok_run, pol_b, sd_b, hold, sh, eb, ebo);
    checks++;
    if ({a_o, a_oe, b_o, b_oe} !== {ea, eao, eb, ebo}) begin
      errors++;
      $display("FAIL %s t=%0t a/aoe/b/boe act=%b%b%b%b exp=%b%b%b%b dt=%0d",
               req, $time, a_o, a_oe, b_o, b_oe, ea, eao, eb, ebo, dt);
    end
  endtask

  // drive after a falling edge, check at the next falling edge
  task automatic tick(input string req);
    @(negedge clk);
    check(req);
  endtask

  initial begin
    #800000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int dts[6] = '{0, 1, 2, 3, 7, 63};
    int widths[10];
    repeat (3) @(negedge clk);
    check("R10");
    rst_n = 1;
    tick("R10");
    tick("R10");

    // dead time and polarity sweep: R1 R2 R3 R4
    foreach (dts[i]) begin
      for (int p = 0; p < 4; p++) begin
        dt = 6'(dts[i]); pol_a = p[0]; pol_b = p[1];
        widths = '{1, 2, 3, 4, dts[i], dts[i] + 1, dts[i] + 2, 5, 70, 1};
        foreach (widths[k]) begin
          int w = (widths[k] < 1) ? 1 : widths[k];
          pwm = ~pwm;
          for (int c = 0; c < w + 1; c++) begin
            string r;
            if (c == w) pwm = pwm;
            if (dts[i] == 0) r = "R1";
            else if (w <= dts[i]) r = "R3";
            else r = (p != 0) ? "R4" : "R2";
            if (c < w) tick(r);
          end
        end
      end
    end

    // shutdown sweep: R5 R6
    dt = 2;
    for (int cfg = 0; cfg < 128; cfg++) begin
      sd_a = cfg[1:0]; sd_b = cfg[3:2]; pol_a = cfg[4]; pol_b = cfg[5];
      oet = cfg[6]; trig_en = cfg[6];
      pwm = cfg[0];
      tick("R6");
      #1 shdn = 1;
      #0.5 check("R6");
      tick("R5");
      pwm = ~pwm;
      tick("R5");
      #1 shdn = 0;
      #0.5 check("R6");
      tick("R6");
      tick("R6");
    end
    oet = 0; trig_en = 0;

    // trigger gating: R7 R8
    dt = 0; pol_a = 0; pol_b = 1;
    oet = 1; trig_en = 1;
    for (int c = 0; c < 5; c++) begin pwm = c[0]; tick("R7"); end
    trig = 1; tick("R7");
    trig = 0;
    for (int c = 0; c < 5; c++) begin pwm = c[1]; tick("R7"); end
    trig_en = 0; tick("R8");
    trig_en = 1; tick("R8");
    tick("R8");
    trig = 1; tick("R7");
    trig = 0; tick("R7");
    oet = 0; trig_en = 0; tick("R8");
    trig_en = 1; tick("R8");
    oet = 1; tick("R8");
    oet = 0;

    // reserved modes: R9
    for (int m = 1; m < 8; m++) begin
      mode = 3'(m); sd_a = 2'b11; sd_b = 2'b10;
      tick("R9");
      shdn = 1; tick("R9");
      shdn = 0; tick("R9");
    end
    mode = 0; tick("R9");

    // reset during activity returns to reset state: R10
    pwm = 1; tick("R10");
    #1 rst_n = 0;
    #0.5 check("R10");
    pwm = 0;
    @(negedge clk); rst_n = 1;
    tick("R10");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule